// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered video lines downward and raises a level interrupt request toward the CPU once a programmed number of lines has passed. The CPU programs it through four write-only registers. The first loads the counter directly. The second stores a reload value. The third turns the interrupt off and acknowledges it. The fourth turns the interrupt on.

A video timing unit supplies a one-cycle strobe for each scanline. The strobe carries the line number and a flag that says whether rendering is active. The counter advances only on visible lines while rendering is on and the interrupt is enabled. It stops advancing while a request is pending. When the counter is found at zero, the block sets its pending flag, asserts the interrupt and reloads the counter from the stored reload value. Line 0 costs one extra count.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset, the counter, the reload value, the enable and the pending flag are zero, and `irq_o` is low.
- R2: A write with `wr_sel_i` = 0 (counter load) sets the counter to `wr_data_i` and clears the pending flag. It leaves `irq_o` unchanged.
- R3: A write with `wr_sel_i` = 1 (reload value) stores `wr_data_i` as the reload value and clears the pending flag. It leaves `irq_o` unchanged.
- R4: A write with `wr_sel_i` = 2 (off/acknowledge) clears the enable and the pending flag, and drives `irq_o` low on the next cycle.
- R5: A write with `wr_sel_i` = 3 (on) sets the enable and clears the pending flag. An `irq_o` that is already high stays high.
- R6: A line strobe counts only when all of the following hold: the line number is between 0 and 239, `render_on_i` is high, the enable is set and no request is pending. Any other strobe leaves the counter unchanged.
- R7: On a counting strobe for line 0, a nonzero counter is first decremented once more, before the normal rule is applied.
- R8: On a counting strobe, a counter that is zero before the decrement sets the pending flag, reloads the counter from the reload value and raises `irq_o` on the next cycle. A nonzero counter decrements by one.
- R9: A write in the same cycle as a line strobe takes priority: that strobe is dropped.
- R10: While a request is pending, strobes do not change the counter, and `irq_o` stays high until an off/acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_sel_i | input | 2 | Register select: 0 load, 1 reload value, 2 off/ack, 3 on |
| wr_data_i | input | 8 | Write data |
| line_stb_i | input | 1 | One-cycle scanline pulse |
| line_num_i | input | 9 | Line number carried by the pulse |
| render_on_i | input | 1 | Rendering enabled flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the line-0 extra decrement. A design that drops it would fire one line late after a frame start, and a design that applies it to a zero counter would wrap and skip the interrupt. It also checks that an enable write leaves a raised line high, and that counting freezes while a request is pending. A design that got either of these wrong would drop the interrupt early or move the counter during the pending window. The bench further collides writes with line pulses, and sends pulses for lines 239 and 240 with rendering both on and off. An error there shows up as a count being taken or lost, which moves the cycle in which `irq_o` rises.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_OFF   = 2'd2,
    SEL_ON    = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/sirq_line_qual.sv
module sirq_line_qual #(
  parameter int LINE_W   = 9,
  parameter int LAST_VIS = 239
) (
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_on_i,
  input  logic              enable_i,
  input  logic              pending_i,
  input  logic              wr_en_i,
  output logic              tick_o,
  output logic              tick_first_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_VIS);

  logic visible;

  always_comb begin
    visible      = (line_num_i <= LastLine);
    tick_o       = line_stb_i && visible && render_on_i && enable_i &&
                   !pending_i && !wr_en_i;
    tick_first_o = tick_o && (line_num_i == '0);
  end
endmodule

// File: rtl/sirq_count_core.sv
module sirq_count_core
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  wr_sel_e          wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             tick_first_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lat_q, lat_d;
  logic [CNT_W-1:0] pre_cnt;
  logic             cnt_ce, lat_ce;

  always_comb begin
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    cnt_ce  = 1'b0;
    lat_ce  = 1'b0;
    fire_o  = 1'b0;
    pre_cnt = (tick_first_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (wr_en_i) begin
      if (wr_sel_i == SEL_LOAD) begin
        cnt_d  = wr_data_i;
        cnt_ce = 1'b1;
      end
      if (wr_sel_i == SEL_LATCH) begin
        lat_d  = wr_data_i;
        lat_ce = 1'b1;
      end
    end else if (tick_i) begin
      cnt_ce = 1'b1;
      if (pre_cnt == '0) begin
        fire_o = 1'b1;
        cnt_d  = lat_q;
      end else begin
        cnt_d  = pre_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (lat_ce) lat_q <= lat_d;
    end
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(wr_en_i && wr_sel_i == SEL_LOAD)) |=> $stable(cnt_q));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == SEL_LATCH) |=> $stable(lat_q));

  // R7
  first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_first_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(2)));
endmodule

// File: rtl/sirq_irq_ctl.sv
module sirq_irq_ctl
  import sirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en_i,
  input  wr_sel_e wr_sel_i,
  input  logic    fire_i,
  output logic    enable_o,
  output logic    pending_o,
  output logic    irq_o
);
  logic en_q, en_d;
  logic pend_q, pend_d;
  logic irq_q, irq_d;

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    irq_d  = irq_q;
    if (wr_en_i) begin
      pend_d = 1'b0;
      if (wr_sel_i == SEL_OFF) begin
        en_d  = 1'b0;
        irq_d = 1'b0;
      end
      if (wr_sel_i == SEL_ON) begin
        en_d = 1'b1;
      end
    end else if (fire_i) begin
      pend_d = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign enable_o  = en_q;
  assign pending_o = pend_q;
  assign irq_o     = irq_q;

  // R4
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_OFF) |=> (!irq_q && !en_q && !pend_q));

  // R5
  on_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_ON && irq_q) |=> (irq_q && en_q));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(fire_i));

  // R9
  write_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> !pend_q);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(wr_en_i && wr_sel_i == SEL_OFF)) |=> irq_q);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import sirq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LINE_W   = 9,
  parameter int LAST_VIS = 239
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              render_on_i,
  output logic              irq_o
);
  wr_sel_e sel;
  logic    tick, tick_first, fire;
  logic    enable, pending;

  assign sel = wr_sel_e'(wr_sel_i);

  sirq_line_qual #(.LINE_W(LINE_W), .LAST_VIS(LAST_VIS)) u_qual (
    .line_stb_i   (line_stb_i),
    .line_num_i   (line_num_i),
    .render_on_i  (render_on_i),
    .enable_i     (enable),
    .pending_i    (pending),
    .wr_en_i      (wr_en_i),
    .tick_o       (tick),
    .tick_first_o (tick_first)
  );

  sirq_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (sel),
    .wr_data_i    (wr_data_i),
    .tick_i       (tick),
    .tick_first_i (tick_first),
    .fire_o       (fire)
  );

  sirq_irq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .fire_i    (fire),
    .enable_o  (enable),
    .pending_o (pending),
    .irq_o     (irq_o)
  );

  // R6
  no_tick_offscreen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb_i && (line_num_i > LINE_W'(LAST_VIS) || !render_on_i)) |-> !fire);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       line_stb;
  logic [8:0] line_num;
  logic       render_on;
  logic       irq;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  string phase = "R1";

  // behavioural reference state
  int  m_cnt, m_lat;
  bit  m_en, m_pend, m_irq;

  scanline_irq_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .line_stb_i(line_stb), .line_num_i(line_num),
    .render_on_i(render_on), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lat = 0; m_en = 0; m_pend = 0; m_irq = 0;
    end else if (wr_en) begin
      m_pend = 0;
      case (wr_sel)
        2'd0: m_cnt = wr_data;
        2'd1: m_lat = wr_data;
        2'd2: begin m_en = 0; m_irq = 0; end
        default: m_en = 1;
      endcase
    end else if (line_stb && line_num < 240 && render_on && m_en && !m_pend) begin
      if (line_num == 0 && m_cnt != 0) m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        m_pend = 1; m_irq = 1; m_cnt = m_lat;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      total++;
      if (irq !== m_irq) begin
        bad++;
        $display("FAIL %s model: irq=%0b expected=%0b at cycle %0d", phase, irq, m_irq, cycles);
      end
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_data = 0; line_stb = 0; line_num = 0; render_on = 1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic line(input int n, input bit ro);
    line_stb = 1; line_num = 9'(n); render_on = ro;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic expect_irq(input bit e, input string tag);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq=%0b expected=%0b", tag, irq, e);
    end
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_irq(0, "R1");

    // R3 and R2: reload 3, counter 2, then R8 fires on the third line
    phase = "R8";
    wr(2'd1, 8'd3);
    wr(2'd0, 8'd2);
    wr(2'd3, 8'd0);
    line(10, 1); line(11, 1);
    expect_irq(0, "R8");
    line(12, 1);
    expect_irq(1, "R8");

    // R10: pending freezes counting, irq holds
    phase = "R10";
    for (int i = 13; i < 20; i++) line(i, 1);
    expect_irq(1, "R10");

    // R5: enable clears pending, irq stays high; counter was reloaded to 3
    phase = "R5";
    wr(2'd3, 8'd0);
    expect_irq(1, "R5");
    // R4: off clears irq
    phase = "R4";
    wr(2'd2, 8'd0);
    expect_irq(0, "R4");
    // re-enable: count 3 -> 4 lines to fire
    wr(2'd3, 8'd0);
    phase = "R8";
    line(20, 1); line(21, 1); line(22, 1);
    expect_irq(0, "R8");
    line(23, 1);
    expect_irq(1, "R8");
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);

    // R6: off-screen lines and rendering off do nothing (counter now 3)
    phase = "R6";
    for (int i = 0; i < 6; i++) line(240 + i, 1);
    for (int i = 0; i < 6; i++) line(30 + i, 0);
    line(239, 1); line(238, 1); line(237, 1);
    expect_irq(0, "R6");
    line(236, 1);
    expect_irq(1, "R6");

    // R7: line 0 extra decrement, counter 3 fires after three lines
    phase = "R7";
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd3);
    wr(2'd3, 8'd0);
    line(0, 1); line(1, 1);
    expect_irq(0, "R7");
    line(2, 1);
    expect_irq(1, "R7");
    // R7: line 0 with zero counter fires directly
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd0);
    line(0, 1);
    expect_irq(1, "R7");

    // R9: write with simultaneous line drops the line
    phase = "R9";
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd1);
    wr(2'd3, 8'd0);
    wr_en = 1; wr_sel = 2'd1; wr_data = 8'd5; line_stb = 1; line_num = 9'd50;
    @(negedge clk);
    idle_inputs();
    line(51, 1);
    expect_irq(0, "R9");
    line(52, 1);
    expect_irq(1, "R9");

    // R2: load does not drop an active irq
    phase = "R2";
    wr(2'd0, 8'd7);
    expect_irq(1, "R2");

    // mixed stimulus against the model
    phase = "R6";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) wr(2'($urandom_range(0, 3)), 8'($urandom_range(0, 6)));
      else if (r < 70) line($urandom_range(0, 261), $urandom_range(0, 9) != 0);
      else if (r < 75) begin
        wr_en = 1; wr_sel = 2'($urandom_range(0, 3)); wr_data = 8'($urandom_range(0, 4));
        line_stb = 1; line_num = 9'($urandom_range(0, 5));
        @(negedge clk);
        idle_inputs();
      end else @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule